// File: doc/BRIEF.md
# SPI Port with Mode-Fault and Write-Collision Detection

An 8-bit serial peripheral port that can act as either the clock-driving master or a selected slave. There is no transmit buffer: a data write goes straight into the shift register. A received byte is copied into a holding register when the byte completes. Software controls the port through four byte-wide registers: control, status, data and pin drive. Bytes shift out most significant bit first. Clock polarity and phase pick one of the four usual sampling arrangements.

The port reports two errors. The first is a mode fault: while it acts as master, its slave-select input is seen low. The port then drops out of master mode and turns off every pin driver, so two masters do not drive the same wires. The second is a write collision: software writes data while a transfer is in progress. The written byte is thrown away and the shifting byte goes on untouched. What counts as "in progress" depends on the role and the clock phase. A master transfer lasts from the data write until completion. A phase-0 slave transfer lasts while it is selected. A phase-1 slave transfer lasts from the first active clock edge until completion, so the select line may stay low across several bytes.

Top module: `spi_fault_port`

## Requirements
- R1: After reset the control, status, data and pin-drive registers read 0, `pin_oe` is 0, `irq` is 0 and `sck_out` is 0.
- R2: As master (control bit 6 enable and bit 4 master set), a data write (address 2) made while idle starts a transfer. SCK runs at the system clock divided by DIV for 8 cycles, bytes go out most significant bit first, and at the end status bit 7 (done) sets and the data register reads the received byte.
- R3: Control bit 3 (CPOL) sets the idle SCK level. With control bit 2 (CPHA) clear, input is sampled on the leading (idle-to-active) edge and output changes on the trailing edge; with it set the two edges swap roles.
- R4: A data write while a transfer is in progress sets status bit 6 (write collision). The byte is dropped and the ongoing transfer delivers its original byte on both the serial line and the receive side.
- R5: A status read (address 1) taken while done or write collision is set, followed by a data-register read or write, clears those flags.
- R6: As a phase-0 slave, a transfer is in progress for as long as slave-select is low. Done sets at the eighth sampling edge, but data writes still collide until slave-select returns high.
- R7: As a phase-1 slave, a transfer starts at the first leading SCK edge and ends when done sets. A write between bytes with slave-select held low is accepted.
- R8: If the port is enabled as master and slave-select is seen low, status bit 4 (mode fault) sets, the control master bit clears and all four pin-drive enables (address 3, bits 3:0) clear.
- R9: `irq` is high only when control bit 7 (interrupt enable) is set, `irq_mask` is low, and done or mode fault is set.
- R10: The mode-fault flag clears only after a status read followed by a control-register (address 0) write.
- R11: A slave selected without a new data write shifts out the byte it received last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data, 3 pin drive |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq_mask | input | 1 | Global interrupt mask, high blocks `irq` |
| irq | output | 1 | Interrupt request |
| sck_in | input | 1 | Serial clock from the master (slave role) |
| sck_out | output | 1 | Generated serial clock (master role) |
| mosi_in | input | 1 | Serial data in (slave role) |
| mosi_out | output | 1 | Serial data out (master role) |
| miso_in | input | 1 | Serial data in (master role) |
| miso_out | output | 1 | Serial data out (slave role) |
| ss_n_in | input | 1 | Slave-select, active low |
| pin_oe | output | 4 | Drive enables: bit 0 SCK, 1 MOSI, 2 MISO, 3 slave-select |

## Verification
The assertions assume that the serial inputs are slow next to the system clock: each SCK level and each select level lasts several clocks, so a single register stage captures every edge, and data is stable around the sampling edge. They also assume that software does not change the role or the clock mode in the middle of a byte. The stimulus holds each slave SCK level for four clocks, changes slave pins one time unit after a rising clock edge, changes the mode only while the port is idle, and runs every master transfer in loopback.

// File: rtl/spi_fault_port.sv
module spi_fault_port #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       irq_mask,
  output logic       irq,
  input  logic       sck_in,
  output logic       sck_out,
  input  logic       mosi_in,
  output logic       mosi_out,
  input  logic       miso_in,
  output logic       miso_out,
  input  logic       ss_n_in,
  output logic [3:0] pin_oe
);

  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic ie_q, en_q, mstr_q, cpol_q, cpha_q;
  logic [3:0] oe_q;
  logic done_f, wcol_f, modf_f;
  logic arm_d, arm_w, arm_m;
  logic [7:0] shreg, rx_q;
  logic out_bit, busy, sck_r;
  logic [2:0] bit_cnt;
  logic [CW-1:0] div_cnt;
  logic [4:0] edge_cnt;
  logic sck_s, sck_p, ss_s, mosi_s, miso_s;

  wire ctl_wr  = reg_wr && reg_addr == 2'd0;
  wire oe_wr   = reg_wr && reg_addr == 2'd3;
  wire data_wr = reg_wr && reg_addr == 2'd2;
  wire data_rd = reg_rd && reg_addr == 2'd2;
  wire sts_rd  = reg_rd && reg_addr == 2'd1;
  wire data_acc = data_wr || data_rd;

  wire is_mst   = en_q && mstr_q;
  wire is_slv   = en_q && !mstr_q;
  wire modf_hit = is_mst && !ss_s;

  wire m_tick  = is_mst && busy && div_cnt == CW'(HALF - 1);
  wire m_lead  = m_tick && !edge_cnt[0];
  wire m_trail = m_tick && edge_cnt[0];
  wire m_end   = m_trail && edge_cnt == 5'd15;

  wire s_act   = is_slv && !ss_s;
  wire s_lead  = s_act && (sck_s != cpol_q) && (sck_p == cpol_q);
  wire s_trail = s_act && (sck_s == cpol_q) && (sck_p != cpol_q);

  wire lead    = m_lead || s_lead;
  wire trail   = m_trail || s_trail;
  wire sample  = cpha_q ? trail : lead;
  wire launch  = cpha_q ? lead : trail;
  wire rx_in   = mstr_q ? miso_s : mosi_s;
  wire last_smp = sample && bit_cnt == 3'd7;

  wire xfer_done = is_mst ? m_end : (is_slv && last_smp);
  wire busy_eff  = busy || (is_slv && !cpha_q && !ss_s);
  wire wr_ok     = data_wr && en_q && !busy_eff;
  wire collide   = data_wr && en_q && busy_eff;
  wire [7:0] shifted = {shreg[6:0], rx_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= 1'b0; sck_p <= 1'b0; ss_s <= 1'b1; mosi_s <= 1'b0; miso_s <= 1'b0;
    end else begin
      sck_s <= sck_in; sck_p <= sck_s; ss_s <= ss_n_in;
      mosi_s <= mosi_in; miso_s <= miso_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= 1'b0; en_q <= 1'b0; mstr_q <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0;
      oe_q <= 4'h0;
    end else begin
      if (ctl_wr) begin
        ie_q   <= reg_wdata[7];
        en_q   <= reg_wdata[6];
        mstr_q <= reg_wdata[4];
        cpol_q <= reg_wdata[3];
        cpha_q <= reg_wdata[2];
      end
      if (oe_wr) oe_q <= reg_wdata[3:0];
      if (modf_hit) begin
        mstr_q <= 1'b0;
        oe_q   <= 4'h0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_f <= 1'b0; wcol_f <= 1'b0; modf_f <= 1'b0;
      arm_d <= 1'b0; arm_w <= 1'b0; arm_m <= 1'b0;
    end else begin
      if (xfer_done) done_f <= 1'b1;
      else if (arm_d && data_acc) done_f <= 1'b0;
      if (collide) wcol_f <= 1'b1;
      else if (arm_w && data_acc) wcol_f <= 1'b0;
      if (modf_hit) modf_f <= 1'b1;
      else if (arm_m && ctl_wr) modf_f <= 1'b0;
      arm_d <= sts_rd ? done_f : (arm_d && done_f && !data_acc);
      arm_w <= sts_rd ? wcol_f : (arm_w && wcol_f && !data_acc);
      arm_m <= sts_rd ? modf_f : (arm_m && modf_f && !ctl_wr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
    end else if (!en_q || modf_hit) begin
      busy <= 1'b0;
    end else if (is_mst) begin
      if (wr_ok) busy <= 1'b1;
      else if (m_end) busy <= 1'b0;
    end else if (ss_s || !cpha_q) begin
      busy <= 1'b0;
    end else if (last_smp) begin
      busy <= 1'b0;
    end else if (s_lead && bit_cnt == 3'd0) begin
      busy <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0; edge_cnt <= 5'd0; sck_r <= 1'b0;
    end else if (!(is_mst && busy) || modf_hit) begin
      div_cnt <= '0; edge_cnt <= 5'd0; sck_r <= cpol_q;
    end else begin
      div_cnt <= m_tick ? '0 : div_cnt + 1'b1;
      if (m_tick) edge_cnt <= edge_cnt + 5'd1;
      if (m_lead) sck_r <= ~cpol_q;
      else if (m_trail) sck_r <= cpol_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= 3'd0; shreg <= 8'h00; rx_q <= 8'h00; out_bit <= 1'b0;
    end else begin
      if (!en_q || modf_hit || (is_slv && ss_s) || wr_ok) bit_cnt <= 3'd0;
      else if (sample) bit_cnt <= bit_cnt + 3'd1;

      if (wr_ok) shreg <= reg_wdata;
      else if (sample) shreg <= shifted;

      if (xfer_done) rx_q <= sample ? shifted : shreg;

      if (wr_ok) out_bit <= reg_wdata[7];
      else if (launch) out_bit <= shreg[7];
      else if (is_slv && ss_s) out_bit <= shreg[7];
    end
  end

  always_comb begin
    unique case (reg_addr)
      2'd0: reg_rdata = {ie_q, en_q, 1'b0, mstr_q, cpol_q, cpha_q, 2'b00};
      2'd1: reg_rdata = {done_f, wcol_f, 1'b0, modf_f, 4'h0};
      2'd2: reg_rdata = rx_q;
      default: reg_rdata = {4'h0, oe_q};
    endcase
  end

  assign sck_out  = sck_r;
  assign mosi_out = out_bit;
  assign miso_out = out_bit;
  assign pin_oe   = en_q ? oe_q : 4'h0;
  assign irq      = ie_q && !irq_mask && (done_f || modf_f);

  assert_modf_drops_master_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && mstr_q && !ss_s) |=> (!mstr_q && oe_q == 4'h0 && modf_f));

  assert_collision_keeps_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy && !sample) |=> (wcol_f && shreg == $past(shreg)));

  assert_mask_blocks_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !irq);

  assert_master_end_sets_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mst && busy && m_end && ss_s) |=> (done_f && !busy));

  assert_slave_hold_collides_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_slv && !cpha_q && !ss_s && data_wr) |=> wcol_f);

endmodule

// File: tb/spi_fault_port_tb_top.sv
module spi_fault_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq_mask = 1'b0;
  logic irq, sck_out, mosi_out, miso_out;
  logic b_sck = 1'b0, b_mosi = 1'b0, b_ss = 1'b1;
  logic [3:0] pin_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  logic cur_master = 1'b1, cur_cpol = 1'b0, cur_cpha = 1'b0, mon_rst = 1'b1;

  always #2 clk = ~clk;

  spi_fault_port #(.DIV(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_mask(irq_mask), .irq(irq),
    .sck_in(b_sck), .sck_out(sck_out), .mosi_in(b_mosi), .mosi_out(mosi_out),
    .miso_in(mosi_out), .miso_out(miso_out), .ss_n_in(b_ss), .pin_oe(pin_oe));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sl_wait();
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic slave_byte(input logic [7:0] mo, input logic mid_wr);
    for (int i = 7; i >= 0; i--) begin
      if (!cur_cpha) begin
        b_mosi = mo[i]; sl_wait(); b_sck = ~cur_cpol; sl_wait(); b_sck = cur_cpol;
      end else begin
        b_sck = ~cur_cpol; b_mosi = mo[i]; sl_wait(); b_sck = cur_cpol; sl_wait();
      end
      if (mid_wr && i == 4) wr(2'd2, 8'hFF);
    end
    sl_wait();
  endtask

  // Scoreboard monitor: rebuilds each byte leaving the port and pops the expected one
  logic prev_sck = 1'b0;
  logic [7:0] cap = 8'h00;
  int cnt = 0;
  always @(negedge clk) begin
    logic ln_sck, ln_d, act;
    logic [7:0] e;
    ln_sck = cur_master ? sck_out : b_sck;
    ln_d   = cur_master ? mosi_out : miso_out;
    act    = cur_master || !b_ss;
    if (mon_rst || !act) cnt = 0;
    else if (ln_sck != prev_sck && ((ln_sck != cur_cpol) == !cur_cpha)) begin
      cap = {cap[6:0], ln_d};
      cnt++;
      if (cnt == 8) begin
        cnt = 0;
        if (exp_q.size() == 0) chk("R3 unexpected serial byte", cap, 8'hxx);
        else begin
          e = exp_q.pop_front();
          chk("R3 serial byte order and edges", cap, e);
        end
      end
    end
    prev_sck = ln_sck;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] bytes [4];
    bytes[0] = 8'hA5; bytes[1] = 8'h1E; bytes[2] = 8'hC7; bytes[3] = 8'h60;
    idle(3); rst_n = 1'b1; idle(2);

    rd(2'd0, d); chk("R1 control reset", d, 8'h00);
    rd(2'd1, d); chk("R1 status reset", d, 8'h00);
    rd(2'd2, d); chk("R1 data reset", d, 8'h00);
    rd(2'd3, d); chk("R1 pin drive reset", d, 8'h00);
    chk("R1 pin_oe/irq/sck reset", {pin_oe, 1'b0, irq, 1'b0, sck_out}, 8'h00);

    wr(2'd3, 8'h0F);
    for (int m = 0; m < 4; m++) begin
      mon_rst = 1'b1;
      cur_master = 1'b1; cur_cpol = m[1]; cur_cpha = m[0];
      wr(2'd0, 8'h50 | 8'(m << 2));
      idle(3); mon_rst = 1'b0;
      chk("R3 sck idle level", {7'd0, sck_out}, {7'd0, cur_cpol});
      exp_q.push_back(bytes[m]);
      wr(2'd2, bytes[m]);
      idle(50);
      rd(2'd1, d); chk("R2 done after master byte", d, 8'h80);
      rd(2'd2, d); chk("R2 loopback receive", d, bytes[m]);
      rd(2'd1, d); chk("R5 flags cleared", d, 8'h00);
      chk("R3 sck back to idle", {7'd0, sck_out}, {7'd0, cur_cpol});
    end
    chk("R8 drivers on before fault", {4'd0, pin_oe}, 8'h0F);

    exp_q.push_back(8'h99);
    wr(2'd2, 8'h99);
    idle(10);
    wr(2'd2, 8'h00);
    idle(50);
    rd(2'd1, d); chk("R4 collision flagged", d, 8'hC0);
    rd(2'd2, d); chk("R4 original byte received", d, 8'h99);
    rd(2'd1, d); chk("R5 both flags cleared", d, 8'h00);

    mon_rst = 1'b1;
    wr(2'd0, 8'hD0);
    idle(3); mon_rst = 1'b0;
    cur_cpol = 1'b0; cur_cpha = 1'b0;
    exp_q.push_back(8'h42);
    wr(2'd2, 8'h42);
    idle(50);
    chk("R9 irq on done", {7'd0, irq}, 8'h01);
    irq_mask = 1'b1; idle(1);
    chk("R9 irq masked", {7'd0, irq}, 8'h00);
    irq_mask = 1'b0;
    rd(2'd1, d); rd(2'd2, d);
    chk("R9 irq low after clear", {7'd0, irq}, 8'h00);

    b_ss = 1'b0; idle(4);
    rd(2'd1, d); chk("R8 mode fault flag", d, 8'h10);
    rd(2'd0, d); chk("R8 master bit cleared", d, 8'hC0);
    rd(2'd3, d); chk("R8 drive enables cleared", d, 8'h00);
    chk("R8 pin_oe port cleared", {4'd0, pin_oe}, 8'h00);
    chk("R9 irq on mode fault", {7'd0, irq}, 8'h01);
    b_ss = 1'b1; cur_master = 1'b0; idle(3);
    wr(2'd2, 8'h3C);
    rd(2'd1, d); chk("R10 fault kept without control write", d, 8'h10);
    wr(2'd0, 8'hC0);
    rd(2'd1, d); chk("R10 fault cleared", d, 8'h00);

    mon_rst = 1'b1;
    cur_cpol = 1'b0; cur_cpha = 1'b0; b_sck = 1'b0;
    wr(2'd0, 8'h40);
    wr(2'd2, 8'h3C);
    idle(3); mon_rst = 1'b0;
    exp_q.push_back(8'h3C);
    b_ss = 1'b0; sl_wait();
    slave_byte(8'h96, 1'b0);
    rd(2'd1, d); chk("R6 done at eighth sample", d, 8'h80);
    wr(2'd2, 8'h11);
    rd(2'd1, d); chk("R6 write blocked while selected", d, 8'h40);
    rd(2'd2, d); chk("R6 slave receive", d, 8'h96);
    rd(2'd1, d); chk("R5 collision cleared", d, 8'h00);
    b_ss = 1'b1; sl_wait();
    wr(2'd2, 8'h5A);
    rd(2'd1, d); chk("R6 write accepted after deselect", d, 8'h00);

    mon_rst = 1'b1;
    cur_cpol = 1'b1; cur_cpha = 1'b1; b_sck = 1'b1;
    wr(2'd0, 8'h4C);
    idle(3); mon_rst = 1'b0;
    exp_q.push_back(8'h5A);
    b_ss = 1'b0; sl_wait();
    slave_byte(8'hC3, 1'b0);
    rd(2'd1, d); chk("R7 done at end of byte", d, 8'h80);
    rd(2'd2, d); chk("R7 slave receive", d, 8'hC3);
    wr(2'd2, 8'h81);
    rd(2'd1, d); chk("R7 gap write accepted", d, 8'h00);
    exp_q.push_back(8'h81);
    slave_byte(8'h7E, 1'b1);
    rd(2'd1, d); chk("R7 mid-byte write collides", d, 8'hC0);
    rd(2'd2, d); chk("R4 slave byte intact", d, 8'h7E);
    b_ss = 1'b1; sl_wait();

    exp_q.push_back(8'h7E);
    b_ss = 1'b0; sl_wait();
    slave_byte(8'h24, 1'b0);
    b_ss = 1'b1; sl_wait();
    rd(2'd1, d); chk("R11 done without reload", d, 8'h80);
    rd(2'd2, d); chk("R11 receive", d, 8'h24);

    idle(5);
    chk("R2 scoreboard drained", 8'(exp_q.size()), 8'h00);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule